// File: doc/BRIEF.md
# Parity-Checked Cache Tag Store with Recovery from an Inclusive Copy

This block holds the tag array of a first-level cache. Every entry is a tag, a valid bit and an even-parity bit over both, and the parity is checked on every read. Because the second level is inclusive, a clean copy of every first-level tag also lives in the second-level tag store. When a lookup finds a parity mismatch, the block does not report a fatal fault. It fetches the entry's copy over a handshake port, rewrites the first-level entry with freshly generated parity, and then runs the lookup again from the start.

One request port carries both lookups and tag installs. Lookups return a registered hit/miss response that also flags whether a repair was needed. Installs take an XOR mask that is applied to the stored word. This is how a bench or a fault campaign places a corrupted entry. A sticky error flag and a saturating count of repaired tags are exposed. Data arrays, line fills and coherence are handled elsewhere.

Top module: `tagrec_top`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o and l2_req_o are 0, err_sticky_o is 0, fix_cnt_o is 0, and every entry is invalid, so any lookup misses.
- R2: An accepted request with req_wr_i=1 stores the word {p, valid, tag} XOR req_flip_i, with p = XOR of valid and all tag bits. Mask bits [TAG_W-1:0] hit the tag, bit TAG_W hits the valid bit and bit TAG_W+1 hits the parity bit. An install produces no response.
- R3: A lookup accepted on edge N whose entry has correct parity gives rsp_valid_o=1 in the cycle after edge N+1, with rsp_hit_o = stored valid AND (stored tag == req_tag_i) and rsp_fixed_o=0.
- R4: An entry whose 14-bit stored word has an odd number of ones is treated as corrupt. A single flipped bit anywhere in tag, valid or parity is detected.
- R5: On detection, l2_req_o rises with l2_idx_o equal to the looked-up index. Both stay unchanged until l2_ack_i is seen at a clock edge.
- R6: The entry is rewritten from l2_tag_i/l2_vld_i with new parity, and the lookup is replayed. Its single response reflects the second-level copy, with rsp_fixed_o=1.
- R7: req_ready_o is 0 from the edge that accepts a lookup until the edge that produces its response. In the response cycle it is 1 again, so lookups can run back to back.
- R8: err_sticky_o goes to 1 on the first detected error and stays 1 until reset.
- R9: fix_cnt_o increases by one for each repair and holds at its maximum (2^CNT_W-1).
- R10: A repaired entry reads clean afterwards. A later lookup to it raises no second-level request and returns rsp_fixed_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_wr_i | input | 1 | 1 = install tag, 0 = lookup |
| req_idx_i | input | IDX_W | Set index |
| req_tag_i | input | TAG_W | Tag to compare or install |
| req_vld_i | input | 1 | Valid bit for an install |
| req_flip_i | input | TAG_W+2 | XOR mask applied to the stored word on install |
| rsp_valid_o | output | 1 | Lookup response strobe |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_fixed_o | output | 1 | Lookup needed a tag repair |
| l2_req_o | output | 1 | Second-level tag read request |
| l2_idx_o | output | IDX_W | Index of the requested copy |
| l2_ack_i | input | 1 | Second-level read done, data valid |
| l2_tag_i | input | TAG_W | Tag copy from second level |
| l2_vld_i | input | 1 | Valid copy from second level |
| err_sticky_o | output | 1 | Sticky tag error flag |
| fix_cnt_o | output | CNT_W | Saturating count of repaired tags |

## Verification
Two events can fall in the same cycle: the response of one lookup and the acceptance of the next, because ready returns in the response cycle. The bench issues lookups back to back on clean entries. A scoreboard then checks that each response pairs with its own request and that ready drops right after every acceptance. A repair can also coincide with the counter already being at its maximum. This is provoked with a long series of single-bit corruptions, and the bench checks that the count holds while the repaired responses stay correct.

// File: rtl/tagrec_pkg.sv
`timescale 1ns/1ps
package tagrec_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_LOOKUP   = 3'd1,
    ST_L2_FETCH = 3'd2,
    ST_REPAIR   = 3'd3,
    ST_REPLAY   = 3'd4
  } tr_state_e;
endpackage

// File: rtl/tagrec_tag_array.sv
`timescale 1ns/1ps
module tagrec_tag_array #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_vld_i,
  input  logic [TAG_W+1:0]  wr_flip_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_vld_o,
  output logic              rd_par_err_o
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int WORD_W = TAG_W + 2;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;

  // even parity: parity bit makes total ones count even
  assign wr_word = {^{wr_vld_i, wr_tag_i}, wr_vld_i, wr_tag_i} ^ wr_flip_i;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        mem[e] <= '0;
      else if (wr_en_i && (wr_idx_i == IDX_W'(e)))        mem[e] <= wr_word;
    end
  end

  assign rd_word      = mem[rd_idx_i];
  assign rd_tag_o     = rd_word[TAG_W-1:0];
  assign rd_vld_o     = rd_word[TAG_W];
  assign rd_par_err_o = ^rd_word;
endmodule

// File: rtl/tagrec_ctrl.sv
`timescale 1ns/1ps
module tagrec_ctrl
  import tagrec_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_wr_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic              req_vld_i,
  input  logic [TAG_W+1:0]  req_flip_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_fixed_o,
  output logic              l2_req_o,
  output logic [IDX_W-1:0]  l2_idx_o,
  input  logic              l2_ack_i,
  input  logic [TAG_W-1:0]  l2_tag_i,
  input  logic              l2_vld_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic              rd_vld_i,
  input  logic              rd_par_err_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [TAG_W-1:0]  wr_tag_o,
  output logic              wr_vld_o,
  output logic [TAG_W+1:0]  wr_flip_o,
  output logic              det_o,
  output logic              fix_o,
  output tr_state_e         state_o
);
  tr_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] fix_tag_q;
  logic             fix_vld_q;
  logic             replay_q;
  logic             rsp_valid_q, rsp_hit_q, rsp_fixed_q;
  logic             hit;

  assign state_o     = state_q;
  assign req_ready_o = (state_q == ST_IDLE);
  assign l2_req_o    = (state_q == ST_L2_FETCH);
  assign l2_idx_o    = idx_q;
  assign rd_idx_o    = idx_q;
  assign det_o       = (state_q == ST_LOOKUP) && rd_par_err_i;
  assign fix_o       = (state_q == ST_REPAIR);
  assign hit         = rd_vld_i && (rd_tag_i == tag_q);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_hit_o   = rsp_hit_q;
  assign rsp_fixed_o = rsp_fixed_q;

  // single write port: repair owns it outside IDLE, installs inside
  always_comb begin
    if (state_q == ST_REPAIR) begin
      wr_en_o   = 1'b1;
      wr_idx_o  = idx_q;
      wr_tag_o  = fix_tag_q;
      wr_vld_o  = fix_vld_q;
      wr_flip_o = '0;
    end else begin
      wr_en_o   = req_ready_o && req_valid_i && req_wr_i;
      wr_idx_o  = req_idx_i;
      wr_tag_o  = req_tag_i;
      wr_vld_o  = req_vld_i;
      wr_flip_o = req_flip_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      tag_q       <= '0;
      fix_tag_q   <= '0;
      fix_vld_q   <= 1'b0;
      replay_q    <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_fixed_q <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i && !req_wr_i) begin
            idx_q    <= req_idx_i;
            tag_q    <= req_tag_i;
            replay_q <= 1'b0;
            state_q  <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          if (rd_par_err_i) begin
            state_q <= ST_L2_FETCH;
          end else begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= hit;
            rsp_fixed_q <= replay_q;
            state_q     <= ST_IDLE;
          end
        end
        ST_L2_FETCH: begin
          if (l2_ack_i) begin
            fix_tag_q <= l2_tag_i;
            fix_vld_q <= l2_vld_i;
            state_q   <= ST_REPAIR;
          end
        end
        ST_REPAIR: begin
          replay_q <= 1'b1;
          state_q  <= ST_REPLAY;
        end
        ST_REPLAY: state_q <= ST_LOOKUP;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tagrec_err_stats.sv
`timescale 1ns/1ps
module tagrec_err_stats #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             det_i,
  input  logic             fix_i,
  output logic             sticky_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sticky_o <= 1'b0;
      cnt_o    <= '0;
    end else begin
      if (det_i) sticky_o <= 1'b1;
      if (fix_i && (cnt_o != CNT_MAX)) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tagrec_top.sv
`timescale 1ns/1ps
module tagrec_top
  import tagrec_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int TAG_W = 12,
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_wr_i,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic              req_vld_i,
  input  logic [TAG_W+1:0]  req_flip_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_fixed_o,
  output logic              l2_req_o,
  output logic [IDX_W-1:0]  l2_idx_o,
  input  logic              l2_ack_i,
  input  logic [TAG_W-1:0]  l2_tag_i,
  input  logic              l2_vld_i,
  output logic              err_sticky_o,
  output logic [CNT_W-1:0]  fix_cnt_o
);
  logic [IDX_W-1:0] rd_idx;
  logic [TAG_W-1:0] rd_tag;
  logic             rd_vld, rd_par_err;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [TAG_W-1:0] wr_tag;
  logic             wr_vld;
  logic [TAG_W+1:0] wr_flip;
  logic             det, fix;
  tr_state_e        state;

  tagrec_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_wr_i, .req_idx_i, .req_tag_i, .req_vld_i, .req_flip_i,
    .rsp_valid_o, .rsp_hit_o, .rsp_fixed_o,
    .l2_req_o, .l2_idx_o, .l2_ack_i, .l2_tag_i, .l2_vld_i,
    .rd_idx_o(rd_idx), .rd_tag_i(rd_tag), .rd_vld_i(rd_vld), .rd_par_err_i(rd_par_err),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_tag_o(wr_tag), .wr_vld_o(wr_vld), .wr_flip_o(wr_flip),
    .det_o(det), .fix_o(fix), .state_o(state)
  );

  tagrec_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_tag_i(wr_tag), .wr_vld_i(wr_vld), .wr_flip_i(wr_flip),
    .rd_idx_i(rd_idx), .rd_tag_o(rd_tag), .rd_vld_o(rd_vld), .rd_par_err_o(rd_par_err)
  );

  tagrec_err_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i, .rst_ni, .det_i(det), .fix_i(fix), .sticky_o(err_sticky_o), .cnt_o(fix_cnt_o)
  );
endmodule

// File: rtl/tagrec_checker.sv
`timescale 1ns/1ps
module tagrec_checker
  import tagrec_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_fixed_o,
  input logic             l2_req_o,
  input logic [IDX_W-1:0] l2_idx_o,
  input logic             l2_ack_i,
  input logic             err_sticky_o,
  input logic [CNT_W-1:0] fix_cnt_o,
  input logic             det,
  input tr_state_e        state
);
  a_r5_l2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l2_req_o && !l2_ack_i |=> l2_req_o && $stable(l2_idx_o));

  a_r5_l2_after_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(l2_req_o) |-> $past(det));

  a_r7_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |-> !req_ready_o);

  a_r7_rsp_in_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> req_ready_o);

  a_r8_sticky_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sticky_o |=> err_sticky_o);

  a_r8_fixed_implies_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fixed_o |-> err_sticky_o);

  a_r9_cnt_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fix_cnt_o) |-> fix_cnt_o == $past(fix_cnt_o) + 1'b1);

  a_r9_cnt_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&fix_cnt_o) |=> (&fix_cnt_o));
endmodule

bind tagrec_top tagrec_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .rsp_fixed_o(rsp_fixed_o), .l2_req_o(l2_req_o), .l2_idx_o(l2_idx_o), .l2_ack_i(l2_ack_i),
  .err_sticky_o(err_sticky_o), .fix_cnt_o(fix_cnt_o), .det(det), .state(state)
);

// File: tb/tagrec_top_bench.sv
`timescale 1ns/1ps
module tagrec_top_bench;
  localparam int IDX_W = 4;
  localparam int TAG_W = 12;
  localparam int CNT_W = 4;
  localparam int DEPTH = 1 << IDX_W;
  localparam int WORD_W = TAG_W + 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic              req_wr_i = 1'b0;
  logic [IDX_W-1:0]  req_idx_i = '0;
  logic [TAG_W-1:0]  req_tag_i = '0;
  logic              req_vld_i = 1'b0;
  logic [WORD_W-1:0] req_flip_i = '0;
  logic              rsp_valid_o, rsp_hit_o, rsp_fixed_o;
  logic              l2_req_o;
  logic [IDX_W-1:0]  l2_idx_o;
  logic              l2_ack_i = 1'b0;
  logic [TAG_W-1:0]  l2_tag_i = '0;
  logic              l2_vld_i = 1'b0;
  logic              err_sticky_o;
  logic [CNT_W-1:0]  fix_cnt_o;

  always #4 clk_i = ~clk_i;

  tagrec_top #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_tagrec_top (.*);

  int n_chk = 0;
  int n_fail = 0;
  int n_l2 = 0;
  bit done = 1'b0;
  logic [IDX_W-1:0] last_idx = '0;

  // models: clean copy (second level) and pending corruption
  logic [TAG_W-1:0] m_tag [DEPTH];
  logic             m_vld [DEPTH];
  bit               m_bad [DEPTH];
  logic [1:0]       exp_q [$];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic install(input int idx, input int tag, input bit vld, input int flip);
    req_valid_i = 1'b1; req_wr_i = 1'b1;
    req_idx_i = IDX_W'(idx); req_tag_i = TAG_W'(tag); req_vld_i = vld; req_flip_i = WORD_W'(flip);
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0; req_wr_i = 1'b0; req_flip_i = '0;
    m_tag[idx] = TAG_W'(tag); m_vld[idx] = vld;
    m_bad[idx] = ($countones(WORD_W'(flip)) % 2) == 1;
  endtask

  // R3 R6 expected: second-level copy decides the hit
  task automatic lookup(input int idx, input int tag);
    exp_q.push_back({m_vld[idx] && (m_tag[idx] == TAG_W'(tag)), m_bad[idx]});
    m_bad[idx] = 1'b0;
    req_valid_i = 1'b1; req_wr_i = 1'b0;
    req_idx_i = IDX_W'(idx); req_tag_i = TAG_W'(tag);
    while (!req_ready_o) @(negedge clk_i);
    last_idx = IDX_W'(idx);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R7 ready low after accept", int'(req_ready_o), 0);
  endtask

  task automatic drain();
    while (!(req_ready_o && exp_q.size() == 0)) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && rsp_valid_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected response", 1, 0);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          chk(rsp_hit_o == e[1], "R3 R6 hit", int'(rsp_hit_o), int'(e[1]));
          chk(rsp_fixed_o == e[0], "R6 R10 fixed flag", int'(rsp_fixed_o), int'(e[0]));
        end
      end
    end
  end

  // second-level responder with two wait cycles
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni && l2_req_o) begin
        n_l2++;
        chk(l2_idx_o == last_idx, "R5 l2 index", int'(l2_idx_o), int'(last_idx));
        for (int w = 0; w < 2; w++) begin
          chk(req_ready_o == 1'b0, "R7 ready low during fetch", int'(req_ready_o), 0);
          @(negedge clk_i);
          chk(l2_req_o == 1'b1, "R5 request held", int'(l2_req_o), 1);
        end
        l2_tag_i = m_tag[l2_idx_o]; l2_vld_i = m_vld[l2_idx_o]; l2_ack_i = 1'b1;
        @(negedge clk_i);
        l2_ack_i = 1'b0;
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int l2_before;
    int n_fix;
    for (int i = 0; i < DEPTH; i++) begin m_tag[i] = '0; m_vld[i] = 1'b0; m_bad[i] = 1'b0; end
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(req_ready_o == 1'b1, "R1 ready", int'(req_ready_o), 1);
    chk(rsp_valid_o == 1'b0, "R1 rsp_valid", int'(rsp_valid_o), 0);
    chk(l2_req_o == 1'b0, "R1 l2_req", int'(l2_req_o), 0);
    chk(err_sticky_o == 1'b0, "R1 sticky", int'(err_sticky_o), 0);
    chk(fix_cnt_o == '0, "R1 count", int'(fix_cnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    lookup(0, 0);                       // R1 entries start invalid
    drain();

    // R2 installs, no response
    for (int i = 0; i < 8; i++) install(i, 12'h100 + i * 23, 1'b1, 0);
    install(8, 12'h123, 1'b0, 0);
    chk(exp_q.size() == 0 && rsp_valid_o == 1'b0, "R2 no install response", int'(rsp_valid_o), 0);
    // R3 R7 back-to-back lookups
    lookup(3, 12'h100 + 3 * 23);
    lookup(3, 12'h7FF);
    lookup(8, 12'h123);
    lookup(6, 12'h100 + 6 * 23);
    drain();
    chk(n_l2 == 0, "R3 clean lookups no fetch", n_l2, 0);
    chk(err_sticky_o == 1'b0, "R8 sticky still clear", int'(err_sticky_o), 0);

    // R4 R6 tag bit flip
    install(5, 12'h2C4, 1'b1, 1 << 2);
    lookup(5, 12'h2C4);
    drain();
    chk(n_l2 == 1, "R4 tag flip fetched", n_l2, 1);
    chk(err_sticky_o == 1'b1, "R8 sticky set", int'(err_sticky_o), 1);
    chk(fix_cnt_o == 1, "R9 count one", int'(fix_cnt_o), 1);
    // R10 entry now clean
    l2_before = n_l2;
    lookup(5, 12'h2C4);
    drain();
    chk(n_l2 == l2_before, "R10 no refetch", n_l2, l2_before);
    // R4 valid bit flip and parity bit flip
    install(9, 12'h0AB, 1'b1, 1 << TAG_W);
    lookup(9, 12'h0AB);
    install(10, 12'h555, 1'b1, 1 << (TAG_W + 1));
    lookup(10, 12'h555);
    lookup(10, 12'h554);
    drain();
    chk(fix_cnt_o == 3, "R9 count three", int'(fix_cnt_o), 3);
    chk(err_sticky_o == 1'b1, "R8 sticky holds", int'(err_sticky_o), 1);

    // R9 saturation under repeated single flips
    n_fix = 3;
    for (int k = 0; k < 17; k++) begin
      install(k % DEPTH, k * 37 + 5, 1'b1, 1 << (k % WORD_W));
      lookup(k % DEPTH, k * 37 + 5);
      drain();
      n_fix++;
      chk(int'(fix_cnt_o) == ((n_fix > 15) ? 15 : n_fix), "R9 saturating count",
          int'(fix_cnt_o), (n_fix > 15) ? 15 : n_fix);
    end
    chk(exp_q.size() == 0, "R6 all responses seen", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule